// File: doc/BRIEF.md
# Binary-Secret Ring-LWE Decryption Unit

This unit recovers an n-bit message from a ring-LWE ciphertext whose secret key has single-bit coefficients. It forms the negacyclic product of the first ciphertext polynomial `u` and the secret polynomial `s`, which is the product modulo x^n+1. It adds the second ciphertext polynomial `v` to that product. It then maps every coefficient of the sum to one message bit. All coefficient arithmetic is modulo q = 256, which is plain 8-bit wrap-around.

Every secret coefficient is one bit, so each partial product is a multiplexer choice between a ciphertext coefficient and zero. The unit contains no integer multiplier. `u` is held in a register that rotates negacyclically once per cycle. On each rotation the top coefficient moves to index 0 and is negated modulo q. The accumulator adds that register into itself whenever the secret bit for that step is set. One secret bit is used per cycle. After the n multiply steps, one more cycle adds `v` and decodes the result. The caller loads the operands in parallel with a start pulse and takes the message when the done pulse appears. The parameter sets in use are n = 256 and n = 512.

Top module: `brlwe_decrypt`

## Requirements
- R1: Coefficient i of `ct_u` and of `ct_v` sits at bits [8i+7:8i]. Bit i of `sec_key` is secret coefficient s_i.
- R2: The result is m_i = decode(v_i + c_i mod 256), where c = u·s mod (x^n+1) with coefficients reduced mod 256. Each partial product is a mux between u_j and 0. The accumulator is cleared on every accepted start.
- R3: A final coefficient w decodes to 1 when 64 <= w < 192, and to 0 otherwise.
- R4: If start is sampled at clock edge k while idle, `done` is high for exactly one cycle, after edge k+n+1. At that same point `msg` holds the new result.
- R5: A start pulse that arrives while a decryption is in progress has no effect on the result or on its timing.
- R6: `msg` keeps its value between done pulses, whatever the inputs do.
- R7: An all-zero secret key yields decode(v_i) for every i.
- R8: A term that is shifted past index n-1 re-enters at the low end with its sign inverted. For a key with only bit n-1 set and every u_j = 64, c_{n-1} = 64 and every other c_i = 192.
- R9: During reset, and after it is released, `done` and `msg` are 0.
- R10: The operands are captured at the accepted start. Changing them later does not alter the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a decryption when the unit is idle |
| ct_u | input | N*8 | First ciphertext polynomial, multiplied by the key |
| ct_v | input | N*8 | Second ciphertext polynomial, added to the product |
| sec_key | input | N | Binary secret polynomial, one bit per coefficient |
| done | output | 1 | One-cycle pulse when `msg` is updated |
| msg | output | N | Decoded message bits |

## Verification
The multiply is driven with several kinds of key:
- Dense random keys exercise many mixed positive and wrapped negative terms at once.
- An all-ones key makes every coefficient the sum of all n terms, which exposes a wrong sign on any wrap.
- A lone bit at index n-1 isolates the negacyclic wrap: a missing negation turns the expected 0s into 1s.
- A lone bit at index 0 tells a correct key-bit order apart from a reversed one.

A zero key places `v` coefficients exactly at 63, 64, 191 and 192, which pins both decode thresholds. Restarts during a run and operand changes after start separate an input that is properly captured at start from one that leaks through.

// File: rtl/brlwe_pkg.sv
package brlwe_pkg;
  localparam int unsigned COEF_W = 8;
  typedef logic [COEF_W-1:0] coef_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_MUL = 2'd1, PH_ADD = 2'd2} phase_e;

  // Sum of two coefficients modulo 2**COEF_W.
  function automatic coef_t coef_add(input coef_t x, input coef_t y);
    return x + y;
  endfunction

  // Additive inverse modulo 2**COEF_W.
  function automatic coef_t coef_neg(input coef_t x);
    return coef_t'(~x + 1'b1);
  endfunction

  // Bit is 1 in the middle half of the ring, [q/4, 3q/4).
  function automatic logic decode_coef(input coef_t w);
    return w[COEF_W-1] ^ w[COEF_W-2];
  endfunction
endpackage

// File: rtl/brlwe_ctrl.sv
module brlwe_ctrl
  import brlwe_pkg::*;
#(
  parameter int unsigned N = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic add_phase,
  output logic done
);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_e         state_q;
  logic [CW-1:0]  cnt_q;
  logic           done_q;
  logic           last_step;

  assign load      = start && (state_q == PH_IDLE);
  assign step      = (state_q == PH_MUL);
  assign add_phase = (state_q == PH_ADD);
  assign last_step = step && (cnt_q == LAST);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= add_phase;
      case (state_q)
        PH_IDLE: if (start) begin
          state_q <= PH_MUL;
          cnt_q   <= '0;
        end
        PH_MUL: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= PH_ADD;
        end
        PH_ADD:  state_q <= PH_IDLE;
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_add_then_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    add_phase |=> done);
  assert_count_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_step) |=> (step && cnt_q == CW'($past(cnt_q) + 1'b1)));
  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start) |=> !load);
endmodule

// File: rtl/brlwe_rotreg.sv
module brlwe_rotreg
  import brlwe_pkg::*;
#(
  parameter int unsigned N = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  coef_t [N-1:0]     u_in,
  input  logic  [N-1:0]     key_in,
  output coef_t [N-1:0]     rot,
  output logic              key_bit
);
  coef_t [N-1:0] rot_q;
  coef_t [N-1:0] rot_next;
  logic  [N-1:0] key_q;

  // Multiply by x modulo x^N+1: the top term wraps with its sign flipped.
  assign rot_next[0] = coef_neg(rot_q[N-1]);
  for (genvar i = 1; i < N; i++) begin : g_shift
    assign rot_next[i] = rot_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_q <= '0;
      key_q <= '0;
    end else if (load) begin
      rot_q <= u_in;
      key_q <= key_in;
    end else if (step) begin
      rot_q <= rot_next;
      key_q <= {1'b0, key_q[N-1:1]};
    end
  end

  assign rot     = rot_q;
  assign key_bit = key_q[0];

  assert_wrap_negates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (coef_add(rot_q[0], $past(rot_q[N-1])) == '0));
  assert_capture_at_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rot_q == $past(u_in)));
endmodule

// File: rtl/brlwe_acc.sv
module brlwe_acc
  import brlwe_pkg::*;
#(
  parameter int unsigned N = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              key_bit,
  input  coef_t [N-1:0]     rot,
  output coef_t [N-1:0]     acc
);
  coef_t [N-1:0] acc_q;
  coef_t [N-1:0] term;

  // Binary secret: each partial product is a mux, never a multiplier.
  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = key_bit ? rot[i] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= '0;
    end else if (step) begin
      for (int i = 0; i < N; i++) acc_q[i] <= coef_add(acc_q[i], term[i]);
    end
  end

  assign acc = acc_q;

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == '0));
  assert_zero_bit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !key_bit && !load) |=> $stable(acc_q));
endmodule

// File: rtl/brlwe_decode.sv
module brlwe_decode
  import brlwe_pkg::*;
#(
  parameter int unsigned N = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              add_phase,
  input  coef_t [N-1:0]     v_in,
  input  coef_t [N-1:0]     acc,
  output logic  [N-1:0]     msg
);
  coef_t [N-1:0] v_q;
  coef_t [N-1:0] fin;
  logic  [N-1:0] bits_w;
  logic  [N-1:0] msg_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign fin[i]    = coef_add(acc[i], v_q[i]);
    assign bits_w[i] = decode_coef(fin[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      msg_q <= '0;
    end else begin
      if (load)      v_q   <= v_in;
      if (add_phase) msg_q <= bits_w;
    end
  end

  assign msg = msg_q;

  assert_msg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !add_phase |=> $stable(msg_q));
  assert_v_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> $stable(v_q));
endmodule

// File: rtl/brlwe_decrypt.sv
module brlwe_decrypt
  import brlwe_pkg::*;
#(
  parameter int unsigned N = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N*COEF_W-1:0]   ct_u,
  input  logic [N*COEF_W-1:0]   ct_v,
  input  logic [N-1:0]          sec_key,
  output logic                  done,
  output logic [N-1:0]          msg
);
  coef_t [N-1:0] u_vec;
  coef_t [N-1:0] v_vec;
  coef_t [N-1:0] rot_w;
  coef_t [N-1:0] acc_w;
  logic          load_w;
  logic          step_w;
  logic          add_w;
  logic          key_bit_w;

  assign u_vec = ct_u;
  assign v_vec = ct_v;

  brlwe_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load_w), .step(step_w), .add_phase(add_w), .done(done)
  );

  brlwe_rotreg #(.N(N)) u_rot (
    .clk(clk), .rst_n(rst_n), .load(load_w), .step(step_w),
    .u_in(u_vec), .key_in(sec_key), .rot(rot_w), .key_bit(key_bit_w)
  );

  brlwe_acc #(.N(N)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(load_w), .step(step_w),
    .key_bit(key_bit_w), .rot(rot_w), .acc(acc_w)
  );

  brlwe_decode #(.N(N)) u_dec (
    .clk(clk), .rst_n(rst_n), .load(load_w), .add_phase(add_w),
    .v_in(v_vec), .acc(acc_w), .msg(msg)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!done && msg == '0));
endmodule

// File: tb/sim_brlwe_decrypt.sv
module sim_brlwe_decrypt;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [N*8-1:0] u;
    logic [N*8-1:0] v;
    logic [N-1:0]   k;
  } vec_t;

  // R1 encoding: byte i of u/v is coefficient i, key bit i is s_i.
  localparam vec_t VECS [6] = '{
    '{64'h3A9107FEC25D48B6, 64'h1F806CE395A40B77, 8'hA5},  // random
    '{64'h0102030405060708, 64'h0000000000000000, 8'hFF},  // all-ones key
    '{64'hFF807F40C02010E0, 64'h4040404040404040, 8'h80},  // lone bit n-1 (R8)
    '{64'hDEADBEEF12345678, 64'h7F80FF00C0BF403F, 8'h00},  // zero key (R7)
    '{64'h55667788_99AABBCC, 64'h8877665544332211, 8'h01}, // lone bit 0
    '{64'hC3E1A05B7D2F9164, 64'h0BAD5EED600DF00D, 8'h3C}   // random
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*8-1:0] ct_u = '0;
  logic [N*8-1:0] ct_v = '0;
  logic [N-1:0]   sec_key = '0;
  logic           done;
  logic [N-1:0]   msg;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brlwe_decrypt #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ct_u(ct_u), .ct_v(ct_v),
    .sec_key(sec_key), .done(done), .msg(msg)
  );

  // Schoolbook negacyclic product in plain integers.
  function automatic logic [N-1:0] model(input logic [N*8-1:0] u, input logic [N*8-1:0] v,
                                         input logic [N-1:0] s);
    int c [N];
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) c[i] = int'(v[8*i +: 8]);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (s[j]) begin
          if (i + j < N) c[i+j] += int'(u[8*i +: 8]);
          else           c[i+j-N] -= int'(u[8*i +: 8]);
        end
    for (int i = 0; i < N; i++) begin
      int w;
      w = ((c[i] % 256) + 256) % 256;
      m[i] = (w >= 64) && (w < 192);
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start on an idle unit; ends just after the edge that raises done.
  task automatic launch(input logic [N*8-1:0] u, input logic [N*8-1:0] v, input logic [N-1:0] k);
    @(negedge clk); ct_u = u; ct_v = v; sec_key = k; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_op(input string req, input logic [N-1:0] exp, input int already);
    repeat (N - already) @(posedge clk);
    @(negedge clk);
    check({req, " R4 done not early"}, N'(done), N'(0));
    @(posedge clk); @(negedge clk);
    check({req, " R4 done"}, N'(done), N'(1));
    check(req, msg, exp);
    @(negedge clk);
    check({req, " R4 single pulse"}, N'(done), N'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset done", N'(done), N'(0));
    check("R9 reset msg", msg, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset msg", msg, '0);

    for (int t = 0; t < 6; t++) begin
      launch(VECS[t].u, VECS[t].v, VECS[t].k);
      finish_op($sformatf("R2 vector %0d", t), model(VECS[t].u, VECS[t].v, VECS[t].k), 0);
    end

    // R3 thresholds and R7 zero key: v = 63,64,191,192,0,255,128,127
    launch(64'h1111111111111111, 64'h7F80FF00C0BF403F, 8'h00);
    finish_op("R3 R7 thresholds", 8'hC6, 0);

    // R8 wrap: every u_j = 64, only s_{n-1} set
    launch(64'h4040404040404040, 64'h0, 8'h80);
    finish_op("R8 wrap sign", 8'h80, 0);

    // R5: second start mid-run with other operands
    launch(VECS[0].u, VECS[0].v, VECS[0].k);
    repeat (3) @(negedge clk);
    ct_u = VECS[5].u; ct_v = VECS[5].v; sec_key = VECS[5].k; start = 1'b1;
    @(negedge clk); start = 1'b0;
    finish_op("R5 busy start", model(VECS[0].u, VECS[0].v, VECS[0].k), 4);

    // R10: operands change after capture, no new start
    launch(VECS[1].u, VECS[1].v, VECS[1].k);
    ct_u = VECS[2].u; ct_v = VECS[2].v; sec_key = VECS[2].k;
    finish_op("R10 capture", model(VECS[1].u, VECS[1].v, VECS[1].k), 0);

    // R6: msg holds while inputs churn
    held = msg;
    ct_u = VECS[3].u; ct_v = VECS[4].v; sec_key = 8'h5A;
    repeat (6) @(negedge clk);
    check("R6 msg hold", msg, held);
    check("R6 no done", N'(done), N'(0));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule